// File: doc/BRIEF.md
# Request-Driven Single-Transfer I/O Engine

This block serves a peripheral that needs one data item carried between one of its registers and a memory buffer each time it raises a service request. A small descriptor selects the direction, the item size (byte or 16-bit word), whether the register-side and buffer-side addresses advance, and whether the peripheral's stop request is honoured. The descriptor also holds the two addresses and a 16-bit transfer counter. On each request the engine reads the source and writes the destination over a simple bus master port. It then steps the pointers and counter and acknowledges the peripheral. When the service ends, it raises a completion interrupt and disarms itself.

Each transfer takes a fixed, predictable number of machine cycles. The engine computes that count from the control bits and from where the two addresses lie. An address is internal below a parameterised boundary and external at or above it. The count also depends on alignment and on whether the external bus is 8 bits wide. The engine holds `busy` for exactly that many cycles and reports the count on `xfer_cycles`.

Top module: `xfer_svc_engine`

## Requirements
- R1: After reset, `busy`, `svc_ack`, `irq`, `armed`, `bus_rd` and `bus_wr` are 0, and `xfer_cycles` is 0.
- R2: When the engine is idle (neither `busy` nor `svc_ack`), a `dsc_load` pulse copies `dsc_ctrl`, `dsc_ioa`, `dsc_bap` and `dsc_cnt` into the descriptor. The copy appears on `cur_ioa`, `cur_bap` and `cur_cnt`. The pulse also sets `armed` and clears `irq`. A `dsc_load` pulse while `busy` is high changes nothing.
- R3: The control field is laid out as follows: bit0 = word size, bit1 = direction (0: register to buffer, 1: buffer to register), bit2 = register pointer advances, bit3 = buffer pointer advances, bit4 = ignore stop requests. The base cost is 32 cycles. Each advancing pointer adds 2, and bit4 set adds 1.
- R4: Each side adds a penalty to the base cost. An internal byte or internal even word adds 0, and an internal odd word adds 2. An external byte or external even word adds 1. An external odd word, or any external word while `ext_bus8` is 1, adds 4. External means the address is at or above `EXT_BASE`. The total cost is the base cost plus both side penalties.
- R5: With `armed` high and the engine idle, a high `svc_req` at a clock edge starts a transfer. `busy` is then high for exactly the total cost in cycles, and `xfer_cycles` shows that cost throughout. `svc_ack` is high for the single cycle after `busy` falls.
- R6: The engine reads from the source address in the first busy cycle (`bus_rd`) and writes to the destination address in the second (`bus_wr`). `bus_word` equals the size bit. A byte is written zero-extended from the low 8 bits read.
- R7: Once a transfer is complete, each pointer whose advance bit is set has moved by 1 (byte) or 2 (word), modulo 2^16.
- R8: Each transfer decrements the counter modulo 2^16. A result of zero raises `irq` and clears `armed`.
- R9: If `svc_stop` is high together with the starting `svc_req` and bit4 is 0, the transfer still completes, then `irq` rises and `armed` clears. With bit4 set, the stop request has no effect.
- R10: While `armed` is 0, `svc_req` starts nothing and `busy` stays low.
- R11: `irq` stays high until the next accepted `dsc_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous active-high reset |
| dsc_load | input | 1 | Load descriptor pulse |
| dsc_ctrl | input | 5 | Control bits (layout in R3) |
| dsc_ioa | input | 16 | Register-side address to load |
| dsc_bap | input | 16 | Buffer-side address to load |
| dsc_cnt | input | 16 | Transfer counter to load |
| ext_bus8 | input | 1 | External bus is 8 bits wide |
| svc_req | input | 1 | Peripheral service request |
| svc_stop | input | 1 | Peripheral stop request |
| svc_ack | output | 1 | One-cycle acknowledge |
| busy | output | 1 | Transfer in progress |
| xfer_cycles | output | 6 | Cost of the current transfer |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_word | output | 1 | Bus access is a word |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| irq | output | 1 | Completion interrupt |
| armed | output | 1 | Service enabled |
| cur_ioa | output | 16 | Current register-side address |
| cur_bap | output | 16 | Current buffer-side address |
| cur_cnt | output | 16 | Current transfer counter |

## Verification
The bench builds the engine with its default parameters: 16-bit addresses, data and counter, and the internal/external boundary at 0x8000. That boundary lets short, hand-picked addresses put either side in either region. With it, every penalty class on both sides can be reached, up to the 45-cycle worst case. The 16-bit widths bring two wrap cases within reach. A buffer pointer at 0xFFFF wraps to zero. A counter loaded with 0 wraps to 0xFFFF without ending the service.

// File: rtl/xfer_svc_pkg.sv
package xfer_svc_pkg;

    localparam int COST_W   = 6;
    localparam int BASE_CYC = 32;
    localparam int UPD_CYC  = 2;
    localparam int IGN_CYC  = 1;
    localparam int MAX_PEN  = 4;
    localparam int MAX_COST = BASE_CYC + 2 * UPD_CYC + IGN_CYC + 2 * MAX_PEN;

    typedef struct packed {
        logic ignore_stop;
        logic buf_upd;
        logic io_upd;
        logic dir;
        logic word;
    } ctrl_t;

    typedef enum logic [1:0] {
        CLS_INT_ALN  = 2'd0,
        CLS_INT_ODD  = 2'd1,
        CLS_EXT_ALN  = 2'd2,
        CLS_EXT_SLOW = 2'd3
    } side_cls_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_ACK  = 2'd2
    } state_t;

    function automatic logic [COST_W-1:0] side_penalty(side_cls_t c);
        case (c)
            CLS_INT_ALN:  return COST_W'(0);
            CLS_INT_ODD:  return COST_W'(2);
            CLS_EXT_ALN:  return COST_W'(1);
            default:      return COST_W'(MAX_PEN);
        endcase
    endfunction

endpackage

// File: rtl/xfer_side_class.sv
module xfer_side_class
    import xfer_svc_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] EXT_BASE = AW'(1) << (AW - 1)
) (
    input  logic [AW-1:0] addr,
    input  logic          word,
    input  logic          ext_bus8,
    output side_cls_t     cls
);

    logic is_ext;
    logic is_odd;

    always_comb begin
        is_ext = (addr >= EXT_BASE);
        is_odd = word & addr[0];
        if (!is_ext) begin
            cls = is_odd ? CLS_INT_ODD : CLS_INT_ALN;
        end else begin
            cls = (is_odd | (word & ext_bus8)) ? CLS_EXT_SLOW : CLS_EXT_ALN;
        end
    end

endmodule

// File: rtl/xfer_cost.sv
module xfer_cost
    import xfer_svc_pkg::*;
(
    input  ctrl_t             ctrl,
    input  side_cls_t         io_cls,
    input  side_cls_t         buf_cls,
    output logic [COST_W-1:0] cycles
);

    logic [COST_W-1:0] base;

    always_comb begin
        base = COST_W'(BASE_CYC);
        if (ctrl.io_upd)      base = base + COST_W'(UPD_CYC);
        if (ctrl.buf_upd)     base = base + COST_W'(UPD_CYC);
        if (ctrl.ignore_stop) base = base + COST_W'(IGN_CYC);
        cycles = base + side_penalty(io_cls) + side_penalty(buf_cls);
    end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_svc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              armed,
    input  logic              svc_req,
    input  logic              svc_stop,
    input  logic              ignore_stop,
    input  logic [COST_W-1:0] cost_in,
    output logic              accept,
    output logic              finish,
    output logic              busy,
    output logic              svc_ack,
    output logic              rd_phase,
    output logic              wr_phase,
    output logic [COST_W-1:0] xfer_cycles,
    output logic              stop_hit
);

    state_t            state_q;
    logic [COST_W-1:0] elapsed_q;

    assign accept   = (state_q == ST_IDLE) && armed && svc_req;
    assign finish   = (state_q == ST_BUSY) && (elapsed_q == xfer_cycles - COST_W'(1));
    assign busy     = (state_q == ST_BUSY);
    assign svc_ack  = (state_q == ST_ACK);
    assign rd_phase = busy && (elapsed_q == COST_W'(0));
    assign wr_phase = busy && (elapsed_q == COST_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            elapsed_q   <= '0;
            xfer_cycles <= '0;
            stop_hit    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q     <= ST_BUSY;
                        elapsed_q   <= '0;
                        xfer_cycles <= cost_in;
                        stop_hit    <= svc_stop & ~ignore_stop;
                    end
                end
                ST_BUSY: begin
                    if (finish) state_q <= ST_ACK;
                    else        elapsed_q <= elapsed_q + COST_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Independent length counter for the busy window
    logic [COST_W-1:0] chk_len;
    always_ff @(posedge clk) begin
        if (rst)       chk_len <= '0;
        else if (busy) chk_len <= chk_len + COST_W'(1);
        else           chk_len <= '0;
    end

    a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
        svc_ack |-> (chk_len == xfer_cycles));

    a_r5_ack_single: assert property (@(posedge clk) disable iff (rst)
        svc_ack |=> !svc_ack);

    a_r5_ack_after_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> svc_ack);

    a_r6_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        rd_phase |=> wr_phase);

    a_r4_cost_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (xfer_cycles >= COST_W'(BASE_CYC) && xfer_cycles <= COST_W'(MAX_COST)));

endmodule

// File: rtl/xfer_svc_engine.sv
module xfer_svc_engine
    import xfer_svc_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 16,
    parameter int            CNTW     = 16,
    parameter logic [AW-1:0] EXT_BASE = AW'(1) << (AW - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dsc_load,
    input  logic [4:0]        dsc_ctrl,
    input  logic [AW-1:0]     dsc_ioa,
    input  logic [AW-1:0]     dsc_bap,
    input  logic [CNTW-1:0]   dsc_cnt,
    input  logic              ext_bus8,
    input  logic              svc_req,
    input  logic              svc_stop,
    output logic              svc_ack,
    output logic              busy,
    output logic [COST_W-1:0] xfer_cycles,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_word,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              armed,
    output logic [AW-1:0]     cur_ioa,
    output logic [AW-1:0]     cur_bap,
    output logic [CNTW-1:0]   cur_cnt
);

    localparam int NSIDE = 2;

    ctrl_t             ctrl_q;
    logic [AW-1:0]     ioa_q;
    logic [AW-1:0]     bap_q;
    logic [CNTW-1:0]   cnt_q;
    logic              armed_q;
    logic              irq_q;
    logic [DW-1:0]     data_q;

    logic [AW-1:0]     side_addr [NSIDE];
    side_cls_t         side_cls  [NSIDE];
    logic [COST_W-1:0] cost;
    logic              accept;
    logic              finish;
    logic              rd_phase;
    logic              wr_phase;
    logic              stop_hit;
    logic              idle;
    logic [AW-1:0]     step;
    logic [AW-1:0]     src_addr;
    logic [AW-1:0]     dst_addr;
    logic [CNTW-1:0]   cnt_next;

    assign side_addr[0] = ioa_q;
    assign side_addr[1] = bap_q;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        xfer_side_class #(
            .AW       (AW),
            .EXT_BASE (EXT_BASE)
        ) u_cls (
            .addr     (side_addr[g]),
            .word     (ctrl_q.word),
            .ext_bus8 (ext_bus8),
            .cls      (side_cls[g])
        );
    end

    xfer_cost u_cost (
        .ctrl    (ctrl_q),
        .io_cls  (side_cls[0]),
        .buf_cls (side_cls[1]),
        .cycles  (cost)
    );

    xfer_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .armed       (armed_q),
        .svc_req     (svc_req),
        .svc_stop    (svc_stop),
        .ignore_stop (ctrl_q.ignore_stop),
        .cost_in     (cost),
        .accept      (accept),
        .finish      (finish),
        .busy        (busy),
        .svc_ack     (svc_ack),
        .rd_phase    (rd_phase),
        .wr_phase    (wr_phase),
        .xfer_cycles (xfer_cycles),
        .stop_hit    (stop_hit)
    );

    assign idle     = !busy && !svc_ack;
    assign step     = ctrl_q.word ? AW'(2) : AW'(1);
    assign src_addr = ctrl_q.dir ? bap_q : ioa_q;
    assign dst_addr = ctrl_q.dir ? ioa_q : bap_q;
    assign cnt_next = cnt_q - CNTW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ioa_q   <= '0;
            bap_q   <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            if (dsc_load && idle) begin
                ctrl_q  <= ctrl_t'(dsc_ctrl);
                ioa_q   <= dsc_ioa;
                bap_q   <= dsc_bap;
                cnt_q   <= dsc_cnt;
                armed_q <= 1'b1;
                irq_q   <= 1'b0;
            end
            if (rd_phase) begin
                data_q <= ctrl_q.word ? bus_rdata : {{(DW-8){1'b0}}, bus_rdata[7:0]};
            end
            if (finish) begin
                cnt_q <= cnt_next;
                if (ctrl_q.io_upd)  ioa_q <= ioa_q + step;
                if (ctrl_q.buf_upd) bap_q <= bap_q + step;
                if (stop_hit || (cnt_next == '0)) begin
                    armed_q <= 1'b0;
                    irq_q   <= 1'b1;
                end
            end
        end
    end

    assign bus_rd    = rd_phase;
    assign bus_wr    = wr_phase;
    assign bus_word  = (rd_phase | wr_phase) & ctrl_q.word;
    assign bus_addr  = rd_phase ? src_addr : (wr_phase ? dst_addr : '0);
    assign bus_wdata = wr_phase ? data_q : '0;
    assign irq       = irq_q;
    assign armed     = armed_q;
    assign cur_ioa   = ioa_q;
    assign cur_bap   = bap_q;
    assign cur_cnt   = cnt_q;

    a_r8_irq_disarms: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !armed);

    a_r10_disarmed_no_start: assert property (@(posedge clk) disable iff (rst)
        (!armed && !busy && !svc_ack) |=> !busy);

    a_r11_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq && !dsc_load) |=> irq);

    a_r2_load_arms: assert property (@(posedge clk) disable iff (rst)
        (dsc_load && !busy && !svc_ack) |=> (armed && !irq));

endmodule

// File: tb/xfer_svc_engine_tb.sv
module xfer_svc_engine_tb;

    typedef struct packed {
        logic [4:0]  ctrl;
        logic [15:0] ioa;
        logic [15:0] bap;
        logic        bus8;
        logic [5:0]  cyc;
    } vec_t;

    // ctrl: [4] ignore stop, [3] buffer advance, [2] register advance, [1] dir, [0] word
    localparam int NVEC = 9;
    localparam vec_t [0:NVEC-1] VECS = '{
        '{5'b00000, 16'h0010, 16'h0200, 1'b0, 6'd32},
        '{5'b00101, 16'h0011, 16'h0200, 1'b0, 6'd36},
        '{5'b01001, 16'h0010, 16'h8201, 1'b0, 6'd38},
        '{5'b11111, 16'h8011, 16'h8201, 1'b0, 6'd45},
        '{5'b10110, 16'h8000, 16'h0005, 1'b0, 6'd36},
        '{5'b01101, 16'h9000, 16'h0100, 1'b1, 6'd40},
        '{5'b00011, 16'h8002, 16'h0003, 1'b0, 6'd35},
        '{5'b11000, 16'h0001, 16'hFFFF, 1'b1, 6'd36},
        '{5'b00001, 16'h0021, 16'h8003, 1'b0, 6'd38}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dsc_load = 1'b0;
    logic [4:0]  dsc_ctrl = '0;
    logic [15:0] dsc_ioa = '0;
    logic [15:0] dsc_bap = '0;
    logic [15:0] dsc_cnt = '0;
    logic        ext_bus8 = 1'b0;
    logic        svc_req = 1'b0;
    logic        svc_stop = 1'b0;
    logic        svc_ack;
    logic        busy;
    logic [5:0]  xfer_cycles;
    logic        bus_rd;
    logic        bus_wr;
    logic        bus_word;
    logic [15:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq;
    logic        armed;
    logic [15:0] cur_ioa;
    logic [15:0] cur_bap;
    logic [15:0] cur_cnt;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign bus_rdata = bus_addr ^ 16'h5A3C;

    xfer_svc_engine u_dut (
        .clk (clk), .rst (rst), .dsc_load (dsc_load), .dsc_ctrl (dsc_ctrl),
        .dsc_ioa (dsc_ioa), .dsc_bap (dsc_bap), .dsc_cnt (dsc_cnt),
        .ext_bus8 (ext_bus8), .svc_req (svc_req), .svc_stop (svc_stop),
        .svc_ack (svc_ack), .busy (busy), .xfer_cycles (xfer_cycles),
        .bus_rd (bus_rd), .bus_wr (bus_wr), .bus_word (bus_word),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq (irq), .armed (armed), .cur_ioa (cur_ioa), .cur_bap (cur_bap),
        .cur_cnt (cur_cnt)
    );

    // Bus monitor, sampled away from the active edge
    logic [15:0] mon_rd_addr, mon_wr_addr, mon_wr_data;
    logic        mon_rd_word;
    int          mon_rd_n, mon_wr_n;
    always @(negedge clk) begin
        if (bus_rd) begin
            mon_rd_addr <= bus_addr;
            mon_rd_word <= bus_word;
            mon_rd_n    <= mon_rd_n + 1;
        end
        if (bus_wr) begin
            mon_wr_addr <= bus_addr;
            mon_wr_data <= bus_wdata;
            mon_wr_n    <= mon_wr_n + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [4:0] c, input logic [15:0] ia,
                        input logic [15:0] ba, input logic [15:0] n);
        @(negedge clk);
        dsc_ctrl = c; dsc_ioa = ia; dsc_bap = ba; dsc_cnt = n; dsc_load = 1'b1;
        @(negedge clk);
        dsc_load = 1'b0;
    endtask

    int   last_len;
    int   last_seen_cyc;
    logic last_ack;

    task automatic run_xfer(input logic stop);
        int n;
        @(negedge clk);
        svc_req = 1'b1; svc_stop = stop;
        @(negedge clk);
        svc_req = 1'b0; svc_stop = 1'b0;
        last_seen_cyc = int'(xfer_cycles);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        last_len = n;
        last_ack = svc_ack;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        mon_rd_n = 0; mon_wr_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "ack", svc_ack, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "armed", armed, 0);
        chk("R1", "bus strobes", {bus_rd, bus_wr}, 0);
        chk("R1", "xfer_cycles", xfer_cycles, 0);

        // R10: request ignored while disarmed
        svc_req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "busy while disarmed", busy, 0);
        svc_req = 1'b0;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] src, dst, rv, exp_io, exp_bp;
            logic        w;
            vec_t        v;
            v = VECS[i];
            w = v.ctrl[0];
            ext_bus8 = v.bus8;
            load(v.ctrl, v.ioa, v.bap, 16'd3);
            chk("R2", "cur_ioa after load", cur_ioa, v.ioa);
            chk("R2", "cur_bap after load", cur_bap, v.bap);
            chk("R2", "armed after load", armed, 1);
            run_xfer(1'b0);
            chk("R5", "busy length", last_len, v.cyc);
            chk("R3", "xfer_cycles", last_seen_cyc, v.cyc);
            chk("R5", "ack after busy", last_ack, 1);
            src = v.ctrl[1] ? v.bap : v.ioa;
            dst = v.ctrl[1] ? v.ioa : v.bap;
            rv  = src ^ 16'h5A3C;
            chk("R6", "read addr", mon_rd_addr, src);
            chk("R6", "write addr", mon_wr_addr, dst);
            chk("R6", "write data", mon_wr_data, w ? rv : {8'h00, rv[7:0]});
            chk("R6", "bus_word", mon_rd_word, w);
            exp_io = v.ioa + (v.ctrl[2] ? (w ? 16'd2 : 16'd1) : 16'd0);
            exp_bp = v.bap + (v.ctrl[3] ? (w ? 16'd2 : 16'd1) : 16'd0);
            chk("R7", "cur_ioa after xfer", cur_ioa, exp_io);
            chk("R7", "cur_bap after xfer", cur_bap, exp_bp);
            chk("R8", "cur_cnt after xfer", cur_cnt, 2);
            chk("R8", "irq stays low", irq, 0);
        end
        ext_bus8 = 1'b0;

        // R4: external word on 8-bit bus, both sides internal otherwise
        load(5'b00001, 16'h8000, 16'h0000, 16'd4);
        ext_bus8 = 1'b1;
        run_xfer(1'b0);
        chk("R4", "8-bit bus word cost", last_len, 36);
        ext_bus8 = 1'b0;

        // R8: counter reaching zero ends service
        load(5'b00000, 16'h0040, 16'h0300, 16'd1);
        run_xfer(1'b0);
        chk("R8", "cnt at zero", cur_cnt, 0);
        chk("R8", "irq raised", irq, 1);
        chk("R8", "disarmed", armed, 0);
        // R10 and R11: further requests ignored, irq held
        svc_req = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10", "no start after end", busy, 0);
        chk("R11", "irq held", irq, 1);
        svc_req = 1'b0;
        load(5'b00000, 16'h0040, 16'h0300, 16'd5);
        chk("R11", "irq cleared by load", irq, 0);

        // R9: honoured stop request
        run_xfer(1'b1);
        chk("R9", "stop honoured cost", last_len, 32);
        chk("R9", "stop raises irq", irq, 1);
        chk("R9", "stop disarms", armed, 0);
        chk("R9", "transfer completed", cur_cnt, 4);

        // R9: ignored stop request
        load(5'b10000, 16'h0040, 16'h0300, 16'd5);
        run_xfer(1'b1);
        chk("R9", "ignored stop cost", last_len, 33);
        chk("R9", "ignored stop no irq", irq, 0);
        chk("R9", "ignored stop armed", armed, 1);

        // R2: load during busy ignored
        load(5'b00100, 16'h0100, 16'h0200, 16'd7);
        @(negedge clk);
        svc_req = 1'b1;
        @(negedge clk);
        svc_req = 1'b0;
        repeat (3) @(negedge clk);
        dsc_ctrl = 5'b00000; dsc_ioa = 16'h7777; dsc_bap = 16'h6666;
        dsc_cnt = 16'd1; dsc_load = 1'b1;
        @(negedge clk);
        dsc_load = 1'b0;
        begin
            int n;
            n = 0;
            while ((busy || svc_ack) && n < 100) begin
                n++;
                @(negedge clk);
            end
        end
        chk("R2", "ioa unchanged by busy load", cur_ioa, 16'h0101);
        chk("R2", "bap unchanged by busy load", cur_bap, 16'h0200);
        chk("R2", "cnt unchanged by busy load", cur_cnt, 16'd6);

        // R8: counter wraps from zero without ending
        load(5'b00000, 16'h0010, 16'h0020, 16'd0);
        run_xfer(1'b0);
        chk("R8", "cnt wrap", cur_cnt, 16'hFFFF);
        chk("R8", "no irq on wrap", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule